// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time as a set of byte registers: seconds, minutes, hour, day of week, day of month, month, year and two copies of the century. Each one-second strobe advances the time by one second. The carry runs from seconds through minutes and hours into the date fields, and on to the century. The block computes the new value of every byte from the current bytes in the same cycle and writes them all back together.

A mode byte chooses how the bytes are encoded and read. Bit 2 picks the number format: 0 for packed BCD, 1 for plain binary. Bit 1 picks 24-hour form when set. When bit 1 is clear, the hour is a 12-hour value and bit 7 of the hour byte marks the afternoon. Bit 7 of the mode byte freezes the counter. A host write port loads any single time byte. Leap years and daylight saving are not modelled. The one-second strobe comes from outside the block.

Top module: `cal_time_counter`

## Requirements
- R1: After a synchronous reset the bytes read 00:00:00, weekday 0, day 1, month 1, year 0, and both century bytes 0. `update_done` is low.
- R2: Seconds advance by one on each accepted strobe. Seconds and minutes wrap from 59 to 0 (0x59 to 0x00 in BCD) and carry one into the next unit. Mode bit 2 = 0 selects BCD and 1 selects binary.
- R3: With mode bit 1 = 0 (12-hour form), bit 7 of the hour marks PM. The hour is moved to 24-hour form, incremented, and converted back: 11 AM rolls to 0x80 (12 noon, PM flag set), and 11 PM rolls to 0x00. Hours of 12 or more are stored as hour minus 12 with bit 7 set.
- R4: When the hour reaches 24 it wraps to 0 and starts a next-day carry into the date fields. With no next-day carry, the date fields keep their values.
- R5: On a next-day carry the weekday becomes (weekday + 1) mod 7.
- R6: A month lasts 31 days for months 1, 3, 5, 7, 8, 10 and 12, and 30 days for months 4, 6, 9 and 11. February always lasts 28 days. Any other month value lasts 30 days. On a next-day carry, a day equal to the month length resets to 1 and the month increments; otherwise the day increments.
- R7: A month reaching 13 resets to 1 and increments the year. A year stepping past 99 resets to 0 and increments the century. Both century bytes take the new century value.
- R8: BCD increments are done nibble by nibble. A low nibble reaching 10 resets to 0 and carries into the high nibble (for example 0x09 becomes 0x10).
- R9: While mode bit 7 is 1, strobes are ignored and every time byte holds its value.
- R10: `update_done` is high for exactly the one cycle that follows each accepted strobe. This is the first cycle in which the new time is visible.
- R11: A host write stores `wr_data` into the selected byte on the next edge. The select codes are: 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month, 6 year, 7 century, 8 second century byte. Codes 9 to 15 change nothing. A write wins over a strobe in the same cycle, and that strobe is dropped without an `update_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-second strobe, one cycle wide |
| mode_cfg | input | 8 | Mode byte: bit 7 freeze, bit 2 binary, bit 1 24-hour |
| wr_en | input | 1 | Host write enable |
| wr_sel | input | SEL_W (4) | Host write byte select |
| wr_data | input | 8 | Host write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour (bit 7 = PM in 12-hour form) |
| wday_o | output | 8 | Day of week, 0 to 6 |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| cent_o | output | 8 | Century |
| cent_alt_o | output | 8 | Second copy of the century |
| update_done | output | 1 | One-cycle pulse after each accepted strobe |

## Verification
Every byte is a register that is read straight at the ports. A wrong carry or a wrong wrap therefore shows up in the cycle after the strobe that causes it, in the byte it touches, and possibly in every byte above it. A fault in the BCD nibble adder or in the 12-hour conversion shows only at particular values: a nibble at 9, an hour at 11, or a day at the end of a month. For that reason the random stimulus is biased toward those values, and the checks compare all nine bytes after every single strobe.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int CAL_DW        = 8;
    localparam int CAL_NIB       = CAL_DW / 2;
    localparam int CAL_FIELDS    = 9;
    localparam int MODE_FREEZE_B = 7;
    localparam int MODE_BIN_B    = 2;
    localparam int MODE_H24_B    = 1;
    localparam int HOUR_PM_B     = 7;
    localparam int UNIT_WRAP     = 60;
    localparam int DAY_HOURS     = 24;
    localparam int HALF_DAY      = 12;
    localparam int YEAR_SPAN     = 100;
    localparam int MONTHS        = 12;
    localparam int WEEK_DAYS     = 7;

    typedef logic [CAL_DW-1:0] cal_byte_t;

    typedef struct packed {
        cal_byte_t sec;
        cal_byte_t min;
        cal_byte_t hour;
        cal_byte_t wday;
        cal_byte_t mday;
        cal_byte_t month;
        cal_byte_t year;
        cal_byte_t cent;
        cal_byte_t cent_alt;
    } cal_time_t;

    typedef enum logic [3:0] {
        SEL_SEC      = 4'd0,
        SEL_MIN      = 4'd1,
        SEL_HOUR     = 4'd2,
        SEL_WDAY     = 4'd3,
        SEL_MDAY     = 4'd4,
        SEL_MONTH    = 4'd5,
        SEL_YEAR     = 4'd6,
        SEL_CENT     = 4'd7,
        SEL_CENT_ALT = 4'd8
    } cal_sel_e;

    typedef struct packed {
        logic freeze;
        logic binary;
        logic h24;
    } cal_mode_t;

    localparam cal_time_t CAL_RESET_TIME = '{
        sec: '0, min: '0, hour: '0, wday: '0, mday: 8'd1,
        month: 8'd1, year: '0, cent: '0, cent_alt: '0
    };

    // Number n written in the selected encoding.
    function automatic cal_byte_t enc_of(input int unsigned n, input logic bin);
        if (bin) return cal_byte_t'(n);
        return {CAL_NIB'((n / 10) % 10), CAL_NIB'(n % 10)};
    endfunction

    // Value of a byte held in the selected encoding.
    function automatic cal_byte_t dec_of(input cal_byte_t v, input logic bin);
        if (bin) return v;
        return cal_byte_t'(v[CAL_DW-1:CAL_NIB] * 10 + v[CAL_NIB-1:0]);
    endfunction

    // Sum in either encoding; bit CAL_DW is the carry out.
    function automatic logic [CAL_DW:0] enc_add(input cal_byte_t a, input cal_byte_t b,
                                                input logic bin);
        logic [CAL_NIB:0] lo;
        logic [CAL_NIB:0] hi;
        logic             c_lo;
        logic             c_hi;
        if (bin) return {1'b0, a} + {1'b0, b};
        lo   = (CAL_NIB+1)'(a[CAL_NIB-1:0]) + (CAL_NIB+1)'(b[CAL_NIB-1:0]);
        c_lo = (lo >= (CAL_NIB+1)'(10));
        if (c_lo) lo = lo - (CAL_NIB+1)'(10);
        hi   = (CAL_NIB+1)'(a[CAL_DW-1:CAL_NIB]) + (CAL_NIB+1)'(b[CAL_DW-1:CAL_NIB])
             + (CAL_NIB+1)'(c_lo);
        c_hi = (hi >= (CAL_NIB+1)'(10));
        if (c_hi) hi = hi - (CAL_NIB+1)'(10);
        return {c_hi, hi[CAL_NIB-1:0], lo[CAL_NIB-1:0]};
    endfunction

    // Number of days in a month, returned in the selected encoding.
    function automatic cal_byte_t month_len(input cal_byte_t m, input logic bin);
        int unsigned days;
        case (dec_of(m, bin))
            8'd1, 8'd3, 8'd5, 8'd7, 8'd8, 8'd10, 8'd12: days = 31;
            8'd2:                                       days = 28;
            default:                                    days = 30;
        endcase
        return enc_of(days, bin);
    endfunction

endpackage

// File: rtl/cal_wrap_unit.sv
module cal_wrap_unit
    import cal_pkg::*;
#(
    parameter int LIMIT = UNIT_WRAP
) (
    input  cal_byte_t val_i,
    input  logic      en_i,
    input  logic      bin_i,
    output cal_byte_t val_o,
    output logic      carry_o
);
    logic [CAL_DW:0] sum;

    always_comb begin
        sum     = enc_add(val_i, enc_of(1, bin_i), bin_i);
        val_o   = val_i;
        carry_o = 1'b0;
        if (en_i) begin
            if (sum[CAL_DW-1:0] == enc_of(LIMIT, bin_i)) begin
                val_o   = '0;
                carry_o = 1'b1;
            end else begin
                val_o = sum[CAL_DW-1:0];
            end
        end
    end
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
    import cal_pkg::*;
(
    input  cal_byte_t hour_i,
    input  logic      en_i,
    input  logic      bin_i,
    input  logic      h24_i,
    output cal_byte_t hour_o,
    output logic      next_day_o
);
    cal_byte_t       lin;
    cal_byte_t       lin_nx;
    logic [CAL_DW:0] pm_sum;
    logic [CAL_DW:0] inc;
    cal_byte_t       half;
    cal_byte_t       low_bits;

    always_comb begin
        half     = enc_of(HALF_DAY, bin_i);
        low_bits = hour_i & ~(cal_byte_t'(1) << HOUR_PM_B);
        pm_sum   = enc_add(low_bits, half, bin_i);
        if (!h24_i && hour_i[HOUR_PM_B]) lin = pm_sum[CAL_DW-1:0];
        else                             lin = hour_i;

        inc        = enc_add(lin, enc_of(1, bin_i), bin_i);
        lin_nx     = inc[CAL_DW-1:0];
        next_day_o = 1'b0;
        if (lin_nx == enc_of(DAY_HOURS, bin_i)) begin
            lin_nx     = '0;
            next_day_o = en_i;
        end

        if (!en_i) begin
            hour_o = hour_i;
        end else if (h24_i || (lin_nx < half)) begin
            hour_o = lin_nx;
        end else begin
            hour_o = enc_of(int'(dec_of(lin_nx, bin_i)) - HALF_DAY, bin_i)
                   | (cal_byte_t'(1) << HOUR_PM_B);
        end
    end
endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
    import cal_pkg::*;
(
    input  cal_time_t cur_i,
    input  logic      en_i,
    input  logic      bin_i,
    output cal_byte_t wday_o,
    output cal_byte_t mday_o,
    output cal_byte_t month_o,
    output cal_byte_t year_o,
    output cal_byte_t cent_o,
    output cal_byte_t cent_alt_o
);
    logic [CAL_DW:0] wd_sum;
    logic [CAL_DW:0] md_sum;
    logic [CAL_DW:0] mo_sum;
    logic [CAL_DW:0] yr_sum;
    logic [CAL_DW:0] ce_sum;
    logic            month_cy;
    logic            year_cy;
    logic            cent_cy;

    always_comb begin
        wd_sum = enc_add(cur_i.wday,  enc_of(1, bin_i), bin_i);
        md_sum = enc_add(cur_i.mday,  enc_of(1, bin_i), bin_i);
        mo_sum = enc_add(cur_i.month, enc_of(1, bin_i), bin_i);
        yr_sum = enc_add(cur_i.year,  enc_of(1, bin_i), bin_i);
        ce_sum = enc_add(cur_i.cent,  enc_of(1, bin_i), bin_i);

        wday_o     = cur_i.wday;
        mday_o     = cur_i.mday;
        month_o    = cur_i.month;
        year_o     = cur_i.year;
        cent_o     = cur_i.cent;
        cent_alt_o = cur_i.cent_alt;
        month_cy   = 1'b0;
        year_cy    = 1'b0;
        cent_cy    = 1'b0;

        if (en_i) begin
            wday_o = wd_sum[CAL_DW-1:0] % cal_byte_t'(WEEK_DAYS);
            if (cur_i.mday != month_len(cur_i.month, bin_i)) begin
                mday_o = md_sum[CAL_DW-1:0];
            end else begin
                mday_o   = enc_of(1, bin_i);
                month_cy = 1'b1;
            end
        end

        if (month_cy) begin
            if (mo_sum[CAL_DW-1:0] == enc_of(MONTHS + 1, bin_i)) begin
                month_o = enc_of(1, bin_i);
                year_cy = 1'b1;
            end else begin
                month_o = mo_sum[CAL_DW-1:0];
            end
        end

        if (year_cy) begin
            year_o = yr_sum[CAL_DW-1:0];
            if (bin_i ? (yr_sum[CAL_DW-1:0] == enc_of(YEAR_SPAN, 1'b1)) : yr_sum[CAL_DW]) begin
                year_o  = '0;
                cent_cy = 1'b1;
            end
        end

        if (cent_cy) begin
            cent_o     = ce_sum[CAL_DW-1:0];
            cent_alt_o = ce_sum[CAL_DW-1:0];
        end
    end
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
    import cal_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int N_LOW  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1s,
    input  logic [7:0]       mode_cfg,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       sec_o,
    output logic [7:0]       min_o,
    output logic [7:0]       hour_o,
    output logic [7:0]       wday_o,
    output logic [7:0]       mday_o,
    output logic [7:0]       month_o,
    output logic [7:0]       year_o,
    output logic [7:0]       cent_o,
    output logic [7:0]       cent_alt_o,
    output logic             update_done
);
    cal_time_t cur_q;
    cal_time_t step_nx;
    cal_time_t time_nx;
    cal_mode_t mode;
    logic      go;
    logic      done_q;

    cal_byte_t low_in   [N_LOW];
    cal_byte_t low_out  [N_LOW];
    logic      low_en   [N_LOW];
    logic      low_cy   [N_LOW];
    logic      day_cy;
    cal_byte_t hour_nx;
    cal_byte_t wday_nx, mday_nx, month_nx, year_nx, cent_nx, cent_alt_nx;

    assign mode.freeze = mode_cfg[MODE_FREEZE_B];
    assign mode.binary = mode_cfg[MODE_BIN_B];
    assign mode.h24    = mode_cfg[MODE_H24_B];
    assign go          = tick_1s && !mode.freeze && !wr_en;

    assign low_in[0] = cur_q.sec;
    assign low_in[1] = cur_q.min;

    // Seconds then minutes: identical wrap-at-60 stages chained by carry.
    for (genvar gi = 0; gi < N_LOW; gi++) begin : g_low
        if (gi == 0) begin : g_first
            assign low_en[gi] = 1'b1;
        end else begin : g_chain
            assign low_en[gi] = low_cy[gi-1];
        end
        cal_wrap_unit #(.LIMIT(UNIT_WRAP)) u_unit (
            .val_i   (low_in[gi]),
            .en_i    (low_en[gi]),
            .bin_i   (mode.binary),
            .val_o   (low_out[gi]),
            .carry_o (low_cy[gi])
        );
    end

    cal_hour_unit u_hour (
        .hour_i     (cur_q.hour),
        .en_i       (low_cy[N_LOW-1]),
        .bin_i      (mode.binary),
        .h24_i      (mode.h24),
        .hour_o     (hour_nx),
        .next_day_o (day_cy)
    );

    cal_date_unit u_date (
        .cur_i      (cur_q),
        .en_i       (day_cy),
        .bin_i      (mode.binary),
        .wday_o     (wday_nx),
        .mday_o     (mday_nx),
        .month_o    (month_nx),
        .year_o     (year_nx),
        .cent_o     (cent_nx),
        .cent_alt_o (cent_alt_nx)
    );

    always_comb begin
        step_nx = '{
            sec: low_out[0], min: low_out[1], hour: hour_nx, wday: wday_nx,
            mday: mday_nx, month: month_nx, year: year_nx, cent: cent_nx,
            cent_alt: cent_alt_nx
        };
        time_nx = cur_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_W'(SEL_SEC):      time_nx.sec      = wr_data;
                SEL_W'(SEL_MIN):      time_nx.min      = wr_data;
                SEL_W'(SEL_HOUR):     time_nx.hour     = wr_data;
                SEL_W'(SEL_WDAY):     time_nx.wday     = wr_data;
                SEL_W'(SEL_MDAY):     time_nx.mday     = wr_data;
                SEL_W'(SEL_MONTH):    time_nx.month    = wr_data;
                SEL_W'(SEL_YEAR):     time_nx.year     = wr_data;
                SEL_W'(SEL_CENT):     time_nx.cent     = wr_data;
                SEL_W'(SEL_CENT_ALT): time_nx.cent_alt = wr_data;
                default:              time_nx          = cur_q;
            endcase
        end else if (go) begin
            time_nx = step_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= CAL_RESET_TIME;
            done_q <= 1'b0;
        end else begin
            cur_q  <= time_nx;
            done_q <= go;
        end
    end

    assign sec_o       = cur_q.sec;
    assign min_o       = cur_q.min;
    assign hour_o      = cur_q.hour;
    assign wday_o      = cur_q.wday;
    assign mday_o      = cur_q.mday;
    assign month_o     = cur_q.month;
    assign year_o      = cur_q.year;
    assign cent_o      = cur_q.cent;
    assign cent_alt_o  = cur_q.cent_alt;
    assign update_done = done_q;

    // R2: binary second 59 wraps to 0 on an accepted strobe
    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (go && mode.binary && cur_q.sec == 8'd59) |=> (cur_q.sec == 8'd0));

    // R3: 11:59:59 PM in binary 12-hour form rolls to midnight
    p_pm_midnight_r3: assert property (@(posedge clk) disable iff (rst)
        (go && mode.binary && !mode.h24 && cur_q.hour == 8'h8B &&
         cur_q.min == 8'd59 && cur_q.sec == 8'd59) |=> (cur_q.hour == 8'h00));

    // R5: a legal weekday stays legal across a strobe
    p_wday_range_r5: assert property (@(posedge clk) disable iff (rst)
        (go && cur_q.wday < 8'd7) |=> (cur_q.wday < 8'd7));

    // R7: a century change from a strobe lands in both century bytes
    p_cent_mirror_r7: assert property (@(posedge clk) disable iff (rst)
        (update_done && cur_q.cent != $past(cur_q.cent)) |-> (cur_q.cent_alt == cur_q.cent));

    // R9: strobes while frozen leave all bytes unchanged
    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tick_1s && mode.freeze && !wr_en) |=> $stable(cur_q));

    // R10: the done pulse is caused only by an accepted strobe
    p_done_cause_r10: assert property (@(posedge clk) disable iff (rst)
        update_done |-> $past(tick_1s && !mode_cfg[MODE_FREEZE_B] && !wr_en));

    // R11: a host write to the seconds byte lands on the next edge
    p_write_sec_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_W'(SEL_SEC)) |=> (cur_q.sec == $past(wr_data)));

endmodule

// File: tb/cal_time_counter_tb.sv
`timescale 1ns/1ps
module cal_time_counter_tb;

    typedef logic [7:0] tv_t [9];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1s = 1'b0;
    logic [7:0] mode_cfg = 8'h00;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, cent_o, cent_alt_o;
    logic       update_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cal_time_counter u_dut (
        .clk(clk), .rst(rst), .tick_1s(tick_1s), .mode_cfg(mode_cfg),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o),
        .cent_alt_o(cent_alt_o), .update_done(update_done)
    );

    function automatic int unsigned dec(input logic [7:0] v, input bit bin);
        return bin ? int'(v) : int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] enc(input int unsigned n, input bit bin);
        return bin ? 8'(n) : {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int unsigned dim(input int unsigned m);
        case (m)
            1, 3, 5, 7, 8, 10, 12: return 31;
            2:                     return 28;
            default:               return 30;
        endcase
    endfunction

    function automatic tv_t ref_step(input tv_t t, input bit bin, input bit h24);
        tv_t r = t;
        int unsigned s, m, h, d, mo, y, c;
        bit nd = 0;
        s = dec(t[0], bin) + 1;
        m = dec(t[1], bin);
        if (h24) h = dec(t[2], bin);
        else     h = dec(t[2] & 8'h7f, bin) + (t[2][7] ? 12 : 0);
        if (s == 60) begin
            s = 0; m = m + 1;
            if (m == 60) begin
                m = 0; h = h + 1;
                if (h == 24) begin h = 0; nd = 1; end
                if (h24)          r[2] = enc(h, bin);
                else if (h < 12)  r[2] = enc(h, bin);
                else              r[2] = enc(h - 12, bin) | 8'h80;
            end
        end
        r[0] = enc(s, bin);
        r[1] = enc(m, bin);
        if (nd) begin
            r[3] = 8'((int'(t[3]) + 1) % 7);
            d  = dec(t[4], bin);
            mo = dec(t[5], bin);
            y  = dec(t[6], bin);
            c  = dec(t[7], bin);
            if (d != dim(mo)) d = d + 1;
            else begin
                d = 1; mo = mo + 1;
                if (mo == 13) begin
                    mo = 1; y = y + 1;
                    if (y == 100) begin
                        y = 0;
                        c = (c + 1) % (bin ? 256 : 100);
                        r[7] = enc(c, bin);
                        r[8] = enc(c, bin);
                    end
                end
            end
            r[4] = enc(d, bin);
            r[5] = enc(mo, bin);
            r[6] = enc(y, bin);
        end
        return r;
    endfunction

    function automatic tv_t get_out();
        tv_t o;
        o[0] = sec_o; o[1] = min_o; o[2] = hour_o; o[3] = wday_o; o[4] = mday_o;
        o[5] = month_o; o[6] = year_o; o[7] = cent_o; o[8] = cent_alt_o;
        return o;
    endfunction

    function automatic string field_req(input int i);
        case (i)
            0, 1:    return "R2";
            2:       return "R3";
            3:       return "R5";
            4:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic load(input tv_t t);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 4'(i); wr_data = t[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Load t, give one strobe, compare every byte against the model.
    task automatic step_check(input tv_t t, input bit bin, input bit h24, input string tag);
        tv_t exp, got;
        mode_cfg = {5'b0, bin, h24, 1'b0};
        load(t);
        exp = ref_step(t, bin, h24);
        tick_1s = 1'b1;
        @(negedge clk);
        check_eq("R10", {tag, " done"}, {7'd0, update_done}, 8'd1);
        tick_1s = 1'b0;
        got = get_out();
        for (int i = 0; i < 9; i++) check_eq(field_req(i), tag, got[i], exp[i]);
        @(negedge clk);
        check_eq("R10", {tag, " done low"}, {7'd0, update_done}, 8'd0);
    endtask

    function automatic tv_t rand_time(input bit bin, input bit h24);
        tv_t t;
        int unsigned mo, h;
        t[0] = enc(($urandom % 3 == 0) ? 59 : $urandom % 60, bin);
        t[1] = enc(($urandom % 3 == 0) ? 59 : $urandom % 60, bin);
        if (h24) begin
            h = ($urandom % 3 == 0) ? 23 : $urandom % 24;
            t[2] = enc(h, bin);
        end else begin
            h = ($urandom % 2 == 0) ? 11 : $urandom % 12;
            t[2] = enc(h, bin) | (($urandom % 2) ? 8'h80 : 8'h00);
        end
        t[3] = 8'($urandom % 7);
        mo = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
        t[5] = enc(mo, bin);
        t[4] = enc(($urandom % 2 == 0) ? dim(mo) : 1 + $urandom % dim(mo), bin);
        t[6] = enc(($urandom % 3 == 0) ? 99 : $urandom % 100, bin);
        t[7] = enc($urandom % 100, bin);
        t[8] = t[7];
        return t;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tv_t t, got;
        void'($urandom(32'h1A2B));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        got = get_out();
        check_eq("R1", "reset sec", got[0], 8'h00);
        check_eq("R1", "reset hour", got[2], 8'h00);
        check_eq("R1", "reset wday", got[3], 8'h00);
        check_eq("R1", "reset mday", got[4], 8'h01);
        check_eq("R1", "reset month", got[5], 8'h01);
        check_eq("R1", "reset cent", got[7], 8'h00);
        check_eq("R1", "reset done", {7'd0, update_done}, 8'd0);

        // R7 R4: BCD 24h end of century 2099-12-31 23:59:59, weekday 6
        t = '{8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h20, 8'h20};
        step_check(t, 0, 1, "bcd century");
        check_eq("R4", "next-day hour", hour_o, 8'h00);
        check_eq("R7", "mirror century", cent_alt_o, 8'h21);

        // R3 R4: binary 12h 11:59:59 PM rolls to midnight and next day
        t = '{8'd59, 8'd59, 8'h8B, 8'd2, 8'd10, 8'd4, 8'd30, 8'd20, 8'd20};
        step_check(t, 1, 0, "pm midnight");
        check_eq("R4", "pm next-day mday", mday_o, 8'd11);

        // R3: 11:59:59 AM rolls to noon with the PM flag
        t = '{8'd59, 8'd59, 8'h0B, 8'd2, 8'd10, 8'd4, 8'd30, 8'd20, 8'd20};
        step_check(t, 1, 0, "am noon");
        check_eq("R3", "noon hour", hour_o, 8'h80);
        check_eq("R4", "no day carry", mday_o, 8'd10);

        // R6: February 28 to March 1 in BCD
        t = '{8'h59, 8'h59, 8'h23, 8'h00, 8'h28, 8'h02, 8'h10, 8'h20, 8'h20};
        step_check(t, 0, 1, "feb end");
        // R6: illegal month 14 counts as 30 days
        t = '{8'd59, 8'd59, 8'd23, 8'd0, 8'd30, 8'd14, 8'd10, 8'd20, 8'd20};
        step_check(t, 1, 1, "odd month");
        check_eq("R6", "odd month len", mday_o, 8'd1);

        // R8: BCD nibble carry 0x09 -> 0x10
        t = '{8'h09, 8'h00, 8'h05, 8'h01, 8'h05, 8'h05, 8'h05, 8'h20, 8'h20};
        step_check(t, 0, 1, "nibble");
        check_eq("R8", "nibble carry", sec_o, 8'h10);

        // R9: frozen counter ignores the strobe
        @(negedge clk);
        mode_cfg = 8'h86;
        tick_1s = 1'b1;
        @(negedge clk);
        tick_1s = 1'b0;
        check_eq("R9", "frozen sec", sec_o, 8'h10);
        check_eq("R9", "frozen done", {7'd0, update_done}, 8'd0);

        // R11: write together with a strobe wins, no done
        mode_cfg = 8'h06;
        wr_en = 1'b1; wr_sel = 4'd0; wr_data = 8'h33; tick_1s = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1s = 1'b0;
        check_eq("R11", "write wins", sec_o, 8'h33);
        check_eq("R11", "write drops strobe", {7'd0, update_done}, 8'd0);
        // R11: unused select code changes nothing
        wr_en = 1'b1; wr_sel = 4'd12; wr_data = 8'h77;
        @(negedge clk);
        wr_en = 1'b0;
        got = get_out();
        check_eq("R11", "unused sel sec", got[0], 8'h33);
        check_eq("R11", "unused sel min", got[1], 8'h00);

        // Random mix of modes and values biased toward rollovers
        for (int k = 0; k < 300; k++) begin
            bit bin, h24;
            bin = 1'($urandom % 2);
            h24 = 1'($urandom % 2);
            t = rand_time(bin, h24);
            step_check(t, bin, h24, "random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule